// File: doc/BRIEF.md
# Indirect Register-to-Peripheral Bus Bridge

This block lets a 64-bit register port reach a 32-bit inner peripheral bus without mapping that bus directly. Software first loads a data register with the word to write, then writes a control word that carries the inner-bus address, a byte count and a read/write select. The write to the control register starts exactly one single-beat transaction on the inner bus. When the inner bus answers, the bridge stores a completion word in a status register. For a read, this word also carries the returned data. Reading the status register hands that word back and clears it, so each completion is seen once.

The sequencing is a three-state machine. In IDLE the bridge waits for a control write. From IDLE, a control write with a legal byte count (1 to 4) takes the transition "issue" to BUSY. A control write with any other count takes "refuse" to REJECT. BUSY holds the inner-bus request until the bus acknowledges or signals an error, and then takes "retire" back to IDLE. REJECT never touches the bus and takes "report" back to IDLE after one cycle. Both "retire" and "report" write the status register on their transition edge.

Bytes travel in big-endian order on little-endian lanes. Lane 0 carries the most significant byte of the data register, lane 1 the next one, and so on. For a read, byte lane k is placed in the same position of the returned word as the byte lane k carries on a write.

Top module: `ibb_bridge`

## Requirements
- R1: After reset, the control, data and status registers all read as zero, and `bus_req` is low.
- R2: A register write with `reg_sel`=1 stores `reg_wdata[63:32]` as the data word. A read with `reg_sel`=1 returns that word in bits 63:32 and zeros in bits 31:0.
- R3: The control word is written with `reg_sel`=0 while the bridge is IDLE. Its fields are the address in bits 31:0, bit 48 (1 = read, 0 = write) and the byte count in bits 59:56. If the count is 1 to 4, `bus_req` rises in the next cycle with `bus_addr` equal to bits 31:0 and `bus_we` equal to the inverse of bit 48. The request and its address, strobes and data stay unchanged until `bus_ack` or `bus_err` is sampled high.
- R4: For a count of n, `bus_be` has its n lowest bits set. On a write, byte lane k (bits 8k+7:8k) carries data-word bits 31-8k:24-8k for k < n, and unused lanes are zero.
- R5: A read that completes with `bus_ack` stores a status word with bit 0 (done) set. Bits 57:26 hold the returned word, whose bits 31-8k:24-8k come from byte lane k of `bus_rdata` for k < n; the rest of the word is zero. A write that completes with `bus_ack` stores status with only bit 0 set.
- R6: In the cycle after `bus_ack` or `bus_err` is sampled, `bus_req` is low and the status done bit is set.
- R7: A transaction that ends with `bus_err` (which wins over `bus_ack`) stores status with bit 0 and bit 1 (error) set and the data field (bits 57:26) zero.
- R8: A read with `reg_sel`=2 returns the status word and clears it at that clock edge. If a completion writes the status register in the same cycle, the new completion word is kept.
- R9: A control write while a transaction is outstanding starts nothing and leaves the control register readback unchanged.
- R10: A data-register write while a transaction is outstanding does not change `bus_wdata` of that transaction.
- R11: A control write with a byte count of 0 or above 4 issues no bus request. The next cycle stores status with done and error set and a zero data field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 status, 3 none |
| reg_wdata | input | 64 | Register write value |
| reg_rdata | output | 64 | Read value of the selected register, valid in the request cycle |
| bus_req | output | 1 | Inner-bus request, held until a response |
| bus_we | output | 1 | Inner-bus direction, 1 = write |
| bus_addr | output | 32 | Inner-bus address |
| bus_be | output | 4 | Inner-bus byte-lane enables |
| bus_wdata | output | 32 | Inner-bus write data, lane ordered |
| bus_rdata | input | 32 | Inner-bus read data, sampled with the response |
| bus_ack | input | 1 | Inner-bus successful completion |
| bus_err | input | 1 | Inner-bus failed completion |

## Verification
The hardest situation to reach from the ports is a status read that falls in the very cycle in which a completion is written. There, clear-on-read and set-on-completion meet in one register. The stimulus starts a read, then drives the acknowledge and the status read in the same cycle. It checks that the old value is returned and that the new completion survives. A second hard case is register traffic during an outstanding transaction. The bench holds off the acknowledge, writes new control and data words while the request is pending, and then checks that the pending request, its write lanes and the control readback stay unchanged. All 16 byte counts are swept in both directions.

// File: rtl/ibb_pkg.sv
package ibb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_REJECT = 2'd2
    } ibb_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } ibb_sel_e;

    localparam int unsigned IBB_REG_W  = 64;
    localparam int unsigned IBB_BUS_AW = 32;
    localparam int unsigned IBB_BUS_DW = 32;

endpackage

// File: rtl/ibb_ctrl_fsm.sv
module ibb_ctrl_fsm
    import ibb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic size_ok_i,
    input  logic rsp_ack_i,
    input  logic rsp_err_i,
    output logic busy_o,
    output logic req_o,
    output logic fin_o,
    output logic fin_err_o
);

    ibb_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: issue, refuse, retire, report
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = size_ok_i ? ST_BUSY : ST_REJECT;
            end
            ST_BUSY: begin
                if (rsp_ack_i || rsp_err_i) state_d = ST_IDLE;
            end
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o    = 1'b1;
        req_o     = 1'b0;
        fin_o     = 1'b0;
        fin_err_o = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_BUSY: begin
                req_o     = 1'b1;
                fin_o     = rsp_ack_i || rsp_err_i;
                fin_err_o = rsp_err_i;
            end
            ST_REJECT: begin
                fin_o     = 1'b1;
                fin_err_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ibb_lane_map.sv
module ibb_lane_map #(
    parameter int unsigned DW   = 32,
    parameter int unsigned SZ_W = 4
) (
    input  logic [SZ_W-1:0] size_i,
    input  logic [DW-1:0]   word_i,
    input  logic [DW-1:0]   lanes_i,
    output logic [DW-1:0]   lanes_o,
    output logic [DW-1:0]   word_o,
    output logic [DW/8-1:0] be_o
);

    localparam int unsigned LANES = DW / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [SZ_W:0] K_IDX = (SZ_W+1)'(k);
        logic on;
        assign on = {1'b0, size_i} > K_IDX;
        assign be_o[k]                     = on;
        assign lanes_o[8*k +: 8]           = on ? word_i[DW-1-8*k -: 8] : 8'h00;
        assign word_o[DW-1-8*k -: 8]       = on ? lanes_i[8*k +: 8]     : 8'h00;
    end

endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
    import ibb_pkg::*;
#(
    parameter int unsigned REG_W    = IBB_REG_W,
    parameter int unsigned AW       = IBB_BUS_AW,
    parameter int unsigned DW       = IBB_BUS_DW,
    parameter int unsigned SZ_W     = 4,
    parameter int unsigned SZ_LSB   = 56,
    parameter int unsigned RNW_BIT  = 48,
    parameter int unsigned RD_LSB   = 26,
    parameter int unsigned DONE_BIT = 0,
    parameter int unsigned ERR_BIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_req,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW/8-1:0]  bus_be,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ack,
    input  logic             bus_err
);

    localparam int unsigned LANES = DW / 8;
    localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(LANES);
    localparam int unsigned DATA_LSB = REG_W - DW;

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] status_q;
    logic [DW-1:0]    data_q;
    logic [AW-1:0]    lat_addr;
    logic             lat_we;
    logic [SZ_W-1:0]  lat_size;
    logic [DW-1:0]    lat_wdata;

    logic             wr_ctrl, wr_data, rd_stat, accept;
    logic [SZ_W-1:0]  cw_size;
    logic             size_ok;
    logic             busy, fin, fin_err;
    logic [DW-1:0]    rd_packed;
    logic [REG_W-1:0] stat_new;

    assign wr_ctrl = reg_req && reg_we  && (reg_sel == SEL_CTRL);
    assign wr_data = reg_req && reg_we  && (reg_sel == SEL_DATA);
    assign rd_stat = reg_req && !reg_we && (reg_sel == SEL_STAT);
    assign accept  = wr_ctrl && !busy;
    assign cw_size = reg_wdata[SZ_LSB +: SZ_W];
    assign size_ok = (cw_size != '0) && (cw_size <= MAX_SZ);

    ibb_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .size_ok_i (size_ok),
        .rsp_ack_i (bus_ack),
        .rsp_err_i (bus_err),
        .busy_o    (busy),
        .req_o     (bus_req),
        .fin_o     (fin),
        .fin_err_o (fin_err)
    );

    ibb_lane_map #(.DW(DW), .SZ_W(SZ_W)) u_lanes (
        .size_i  (lat_size),
        .word_i  (lat_wdata),
        .lanes_i (bus_rdata),
        .lanes_o (bus_wdata),
        .word_o  (rd_packed),
        .be_o    (bus_be)
    );

    // transaction payload captured on "issue"/"refuse"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_size  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            ctrl_q    <= reg_wdata;
            lat_addr  <= reg_wdata[AW-1:0];
            lat_we    <= !reg_wdata[RNW_BIT];
            lat_size  <= cw_size;
            lat_wdata <= data_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= reg_wdata[REG_W-1 -: DW];
    end

    always_comb begin
        stat_new           = '0;
        stat_new[DONE_BIT] = 1'b1;
        stat_new[ERR_BIT]  = fin_err;
        if (!fin_err && !lat_we) stat_new[RD_LSB +: DW] = rd_packed;
    end

    // completion wins over clear-on-read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       status_q <= '0;
        else if (fin)     status_q <= stat_new;
        else if (rd_stat) status_q <= '0;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_DATA: reg_rdata = {data_q, {DATA_LSB{1'b0}}};
            SEL_STAT: reg_rdata = status_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign bus_we   = lat_we;
    assign bus_addr = lat_addr;

endmodule

// File: rtl/ibb_bridge_chk.sv
module ibb_bridge_chk #(
    parameter int unsigned REG_W    = 64,
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned RD_LSB   = 26,
    parameter int unsigned DONE_BIT = 0,
    parameter int unsigned ERR_BIT  = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_req,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic             bus_req,
    input logic             bus_ack,
    input logic             bus_err,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW/8-1:0]  bus_be,
    input logic [REG_W-1:0] ctrl_q,
    input logic [REG_W-1:0] status_q,
    input logic             fin
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_err |=>
            bus_req && $stable(bus_addr) && $stable(bus_be))
        else $error("request not held");

    // R10: lanes of an outstanding write stay fixed
    p_wdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_err |=> $stable(bus_wdata))
        else $error("write lanes changed");

    p_be_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_be != '0) && ((bus_be & (bus_be + 1'b1)) == '0))
        else $error("strobes not contiguous from lane 0");

    p_done_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_ack || bus_err) |=> !bus_req && status_q[DONE_BIT])
        else $error("done not set after response");

    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_err |=>
            status_q[ERR_BIT] && (status_q[RD_LSB +: DW] == '0))
        else $error("error completion wrong");

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_we && (reg_sel == 2'd2) && !fin |=> status_q == '0)
        else $error("status not cleared");

    p_fin_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> status_q[DONE_BIT])
        else $error("completion lost");

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && reg_req && reg_we && (reg_sel == 2'd0) |=>
            ctrl_q == $past(ctrl_q))
        else $error("control changed while busy");

endmodule

bind ibb_bridge ibb_bridge_chk #(
    .REG_W(REG_W), .AW(AW), .DW(DW),
    .RD_LSB(RD_LSB), .DONE_BIT(DONE_BIT), .ERR_BIT(ERR_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .fin       (fin)
);

// File: tb/ibb_bridge_tb.sv
`timescale 1ns/1ps
module ibb_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #2.5 clk = ~clk;

    ibb_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lanes(input logic [31:0] d, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) if (k < n) r[8*k +: 8] = d[31-8*k -: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] l, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) if (k < n) r[31-8*k -: 8] = l[8*k +: 8];
        return r;
    endfunction

    function automatic logic [63:0] mk_ctrl(input bit rnw, input int sz, input logic [31:0] a);
        logic [63:0] c = '0;
        c[31:0]  = a;
        c[48]    = rnw;
        c[59:56] = 4'(sz);
        return c;
    endfunction

    task automatic reg_wr(input logic [1:0] sel, input logic [63:0] v);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [63:0] v);
        reg_req = 1'b1; reg_we = 1'b0; reg_sel = sel;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic run_xfer(input bit rnw, input int sz, input logic [31:0] a,
                            input logic [31:0] wd, input logic [31:0] rd,
                            input int dly, input bit err);
        logic [63:0] v, exp_st;
        bit legal = (sz >= 1) && (sz <= 4);
        reg_wr(2'd1, {wd, 32'h0});
        reg_wr(2'd0, mk_ctrl(rnw, sz, a));
        if (legal) begin
            chk("R3 req raised", 64'(bus_req), 64'd1);
            chk("R3 addr", 64'(bus_addr), 64'(a));
            chk("R3 dir", 64'(bus_we), 64'(!rnw));
            chk("R4 strobes", 64'(bus_be), 64'((1 << sz) - 1));
            if (!rnw) chk("R4 write lanes", 64'(bus_wdata), 64'(exp_lanes(wd, sz)));
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk("R3 req held", 64'(bus_req), 64'd1);
            end
            bus_ack = !err; bus_err = err; bus_rdata = rd;
            @(negedge clk);
            bus_ack = 1'b0; bus_err = 1'b0;
            chk("R6 req dropped", 64'(bus_req), 64'd0);
            exp_st = 64'd1;
            if (err) exp_st[1] = 1'b1;
            else if (rnw) exp_st[57:26] = exp_word(rd, sz);
        end else begin
            chk("R11 no request", 64'(bus_req), 64'd0);
            @(negedge clk);
            chk("R11 still no request", 64'(bus_req), 64'd0);
            exp_st = 64'd3;
        end
        reg_rd(2'd2, v);
        chk(legal ? (err ? "R7 status" : "R5 status") : "R11 status", v, exp_st);
        reg_rd(2'd2, v);
        chk("R8 cleared", v, 64'd0);
    endtask

    initial begin
        logic [63:0] v, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 req", 64'(bus_req), 64'd0);
        reg_rd(2'd0, v); chk("R1 ctrl", v, 64'd0);
        reg_rd(2'd1, v); chk("R1 data", v, 64'd0);
        reg_rd(2'd2, v); chk("R1 status", v, 64'd0);

        reg_wr(2'd1, 64'hA5A5_1234_FFFF_0000);
        reg_rd(2'd1, v); chk("R2 data readback", v, 64'hA5A5_1234_0000_0000);

        for (int rnw = 0; rnw < 2; rnw++)
            for (int sz = 0; sz < 16; sz++)
                for (int p = 0; p < 2; p++)
                    run_xfer(rnw[0], sz, 32'h1000_0000 + 32'(sz * 'h111 + p),
                             (p ? 32'h1357_9BDF : 32'hC0DE_F00D) ^ 32'(sz),
                             (p ? 32'hA1B2_C3D4 : 32'h0F1E_2D3C) ^ 32'(sz << 8),
                             (sz + p) % 3, (sz == 3) && (p == 1));

        // R9 / R10: traffic during an outstanding write
        reg_wr(2'd1, {32'h1122_3344, 32'h0});
        c0 = mk_ctrl(1'b0, 4, 32'h0000_0040);
        reg_wr(2'd0, c0);
        reg_wr(2'd0, mk_ctrl(1'b1, 2, 32'h0000_0999));
        reg_wr(2'd1, 64'hFFFF_FFFF_0000_0000);
        chk("R9 addr kept", 64'(bus_addr), 64'h40);
        chk("R9 dir kept", 64'(bus_we), 64'd1);
        chk("R10 lanes kept", 64'(bus_wdata), 64'h4433_2211);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R9 single transfer", 64'(bus_req), 64'd0);
        reg_rd(2'd0, v); chk("R9 ctrl readback", v, c0);
        reg_rd(2'd2, v); chk("R5 write status", v, 64'd1);

        // R8: status read collides with completion
        reg_wr(2'd0, mk_ctrl(1'b1, 4, 32'h0000_0080));
        bus_ack = 1'b1; bus_rdata = 32'hA1B2_C3D4;
        reg_req = 1'b1; reg_we = 1'b0; reg_sel = 2'd2;
        #1 chk("R8 old value on collision", reg_rdata, 64'd0);
        @(negedge clk);
        bus_ack = 1'b0; reg_req = 1'b0;
        reg_rd(2'd2, v);
        chk("R8 completion kept", v, 64'd1 | (64'(32'hD4C3_B2A1) << 26));

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule